// File: doc/BRIEF.md
# Truncating Float-to-Integer Converter

This block turns a floating-point number, held in an unpacked form (sign, class code, unbiased exponent and a wide mantissa whose lowest bits act as guard and round positions, plus a separate sticky input), into a signed two's-complement integer. A mode input picks a 32-bit or a 64-bit result. The conversion always drops the fractional part, moving the value toward zero. Any rounding-mode setting elsewhere in the unit has no bearing on it.

Values that do not fit, infinities and NaNs are clamped to the largest integer of the same sign as the input and raise an invalid-conversion flag. In-range results that lost nonzero fraction bits raise an inexact flag. The upper limit depends on the sign, so the most negative integer of each width can still be produced. A request is taken when `inValid` is high and its result appears on the registered outputs one clock later with `outValid`.

Top module: `ftoi_trunc`

## Requirements
- R1: While `rstN` is low, and after it rises, `outValid`, `outData`, `outInvalid` and `outInexact` are all 0 until a request is accepted.
- R2: A request with `inValid` high gives `outValid` high exactly one clock later. The data and flag outputs keep their values on every cycle in which `inValid` is low.
- R3: Class code 0 (zero) gives `outData` = 0 and both flags low, whatever the sign, exponent, mantissa and sticky inputs are.
- R4: For class code 1 (number), the value is `inMant` × 2^(`inExp` − 65), where mantissa bit 65 weighs 2^`inExp`. A positive in-range input gives the integer part of that value, with the fraction dropped.
- R5: A negative in-range input (`inSign` = 1) gives the two's-complement negation of the truncated magnitude.
- R6: `outInexact` is high when an in-range conversion drops any nonzero mantissa bit or `inSticky` is 1. It is low when the conversion is exact.
- R7: A negative exponent gives 0. `outInexact` is then high exactly when the mantissa or the sticky input is nonzero.
- R8: An exponent of 32 or more in 32-bit mode (`inWide` = 0), or of 64 or more in 64-bit mode (`inWide` = 1), saturates and raises `outInvalid`.
- R9: The magnitude limit depends on the sign. A positive magnitude of 2^31 (2^63 in 64-bit mode) or more overflows. A negative magnitude overflows only above that value, so -2^31 (-2^63) is produced exactly.
- R10: Class codes 2 (infinity) and 3 (NaN) saturate by sign and raise `outInvalid`.
- R11: The saturated value is 0x7FFFFFFF for positive and 0x80000000 for negative inputs in 32-bit mode, and 0x7FFFFFFFFFFFFFFF or 0x8000000000000000 in 64-bit mode. A saturated result never has `outInexact` set.
- R12: In 32-bit mode, bits 63 to 32 of `outData` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Request strobe |
| inWide | input | 1 | 1 selects a 64-bit result, 0 a 32-bit result |
| inSign | input | 1 | Sign of the operand, 1 is negative |
| inClass | input | 2 | 0 zero, 1 number, 2 infinity, 3 NaN |
| inExp | input | 12 | Unbiased exponent, signed |
| inMant | input | 66 | Mantissa, bit 65 weighs 2^inExp |
| inSticky | input | 1 | OR of bits already lost below the mantissa |
| outValid | output | 1 | Result strobe, one clock after the request |
| outData | output | 64 | Integer result, zero-extended in 32-bit mode |
| outInvalid | output | 1 | Invalid-conversion flag |
| outInexact | output | 1 | Fraction-lost flag |

## Verification
The bound checker checks on every cycle the one-clock valid timing, the holding of results between requests, the saturation pattern that goes with every invalid flag, the exclusion of the two flags, the clean upper half in 32-bit mode, the sign of every nonzero in-range result and the forced outcomes for zero, infinity, NaN and large exponents. Only the bench's scenarios show that the truncated magnitudes are numerically correct, that the inexact flag follows exactly the bits dropped, and that the sign-dependent limit sits exactly at 2^31 and 2^63. The bench uses a vector table for these boundaries and a randomized comparison against its own arithmetic model.

// File: rtl/ftoi_pkg.sv
package ftoi_pkg;

  typedef enum logic [1:0] {
    CLS_ZERO = 2'd0,
    CLS_NUM  = 2'd1,
    CLS_INF  = 2'd2,
    CLS_NAN  = 2'd3
  } numClass_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;       // capture a new result
    logic wide;       // 64-bit result width
    logic neg;        // operand is negative
    logic forceZero;  // zero class, result is 0 with no flags
    logic forceSat;   // special class or exponent out of range
  } ctrlStrobe_t;

endpackage

// File: rtl/ftoi_ctrl.sv
module ftoi_ctrl
  import ftoi_pkg::*;
#(
  parameter int INT_W    = 64,
  parameter int NARROW_W = 32,
  parameter int MANT_W   = 66,
  parameter int EXP_W    = 12,
  parameter int SH_W     = 7
) (
  input  logic                    inValid,
  input  logic                    inWide,
  input  logic                    inSign,
  input  logic [1:0]              inClass,
  input  logic signed [EXP_W-1:0] inExp,
  output ctrlStrobe_t             ctrl,
  output logic [SH_W-1:0]         shAmt
);

  localparam int FRAC_W = MANT_W - 1;

  logic signed [EXP_W:0] expExt;
  logic signed [EXP_W:0] expLimit;
  logic signed [EXP_W:0] shDiff;
  logic                  expOver;
  logic                  expNeg;
  logic                  isSpecial;

  always_comb begin
    expExt    = {inExp[EXP_W-1], inExp};
    expLimit  = inWide ? (EXP_W+1)'(INT_W) : (EXP_W+1)'(NARROW_W);
    expOver   = expExt >= expLimit;
    expNeg    = inExp[EXP_W-1];
    isSpecial = (inClass == CLS_INF) || (inClass == CLS_NAN);
    shDiff    = (EXP_W+1)'(FRAC_W) - expExt;
    // a negative exponent shifts everything out, dropping all bits
    shAmt     = expNeg ? SH_W'(MANT_W) : SH_W'(shDiff);
  end

  always_comb begin
    ctrl.load      = inValid;
    ctrl.wide      = inWide;
    ctrl.neg       = inSign;
    ctrl.forceZero = (inClass == CLS_ZERO);
    ctrl.forceSat  = isSpecial || ((inClass == CLS_NUM) && expOver);
  end

endmodule

// File: rtl/ftoi_dpath.sv
module ftoi_dpath
  import ftoi_pkg::*;
#(
  parameter int INT_W    = 64,
  parameter int NARROW_W = 32,
  parameter int MANT_W   = 66,
  parameter int SH_W     = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       ctrl,
  input  logic [SH_W-1:0]   shAmt,
  input  logic [MANT_W-1:0] inMant,
  input  logic              inSticky,
  output logic              outValid,
  output logic [INT_W-1:0]  outData,
  output logic              outInvalid,
  output logic              outInexact
);

  localparam int PAD_W = INT_W - NARROW_W;
  localparam logic [MANT_W-1:0] WIDE_BOUND   = MANT_W'(1) << (INT_W - 1);
  localparam logic [MANT_W-1:0] NARROW_BOUND = MANT_W'(1) << (NARROW_W - 1);
  localparam logic [INT_W-1:0]    WIDE_MAX   = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic [NARROW_W-1:0] NARROW_MAX = {1'b0, {(NARROW_W-1){1'b1}}};

  logic [MANT_W-1:0]   shifted;
  logic [MANT_W-1:0]   dropMask;
  logic [MANT_W-1:0]   magLimit;
  logic                lost;
  logic                magOver;
  logic [INT_W-1:0]    mag;
  logic [INT_W-1:0]    signedVal;
  logic [INT_W-1:0]    sizedVal;
  logic [INT_W-1:0]    satVal;
  logic [NARROW_W-1:0] satNarrow;
  logic                doSat;
  logic [INT_W-1:0]    nextData;
  logic                nextInvalid;
  logic                nextInexact;

  // alignment shift and collection of the bits it drops
  always_comb begin
    shifted  = inMant >> shAmt;
    dropMask = ~({MANT_W{1'b1}} << shAmt);
    lost     = (|(inMant & dropMask)) | inSticky;
  end

  // sign-dependent range check
  always_comb begin
    magLimit = (ctrl.wide ? WIDE_BOUND : NARROW_BOUND) + MANT_W'(ctrl.neg);
    magOver  = shifted >= magLimit;
  end

  // sign application and width selection
  always_comb begin
    mag       = shifted[INT_W-1:0];
    signedVal = ctrl.neg ? (~mag + INT_W'(1)) : mag;
    sizedVal  = ctrl.wide ? signedVal
                          : {{PAD_W{1'b0}}, signedVal[NARROW_W-1:0]};
    satNarrow = NARROW_MAX + NARROW_W'(ctrl.neg);
    satVal    = ctrl.wide ? (WIDE_MAX + INT_W'(ctrl.neg))
                          : {{PAD_W{1'b0}}, satNarrow};
  end

  always_comb begin
    doSat       = ctrl.forceSat || (!ctrl.forceZero && magOver);
    nextInvalid = !ctrl.forceZero && doSat;
    nextInexact = !ctrl.forceZero && !doSat && lost;
    if (ctrl.forceZero) begin
      nextData = '0;
    end else if (doSat) begin
      nextData = satVal;
    end else begin
      nextData = sizedVal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      outData    <= '0;
      outInvalid <= 1'b0;
      outInexact <= 1'b0;
    end else begin
      outValid <= ctrl.load;
      if (ctrl.load) begin
        outData    <= nextData;
        outInvalid <= nextInvalid;
        outInexact <= nextInexact;
      end
    end
  end

endmodule

// File: rtl/ftoi_trunc.sv
module ftoi_trunc
  import ftoi_pkg::*;
#(
  parameter int INT_W    = 64,
  parameter int NARROW_W = 32,
  parameter int MANT_W   = 66,
  parameter int EXP_W    = 12
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  input  logic                    inWide,
  input  logic                    inSign,
  input  logic [1:0]              inClass,
  input  logic signed [EXP_W-1:0] inExp,
  input  logic [MANT_W-1:0]       inMant,
  input  logic                    inSticky,
  output logic                    outValid,
  output logic [INT_W-1:0]        outData,
  output logic                    outInvalid,
  output logic                    outInexact
);

  localparam int SH_W = $clog2(MANT_W + 1);

  ctrlStrobe_t     ctrl;
  logic [SH_W-1:0] shAmt;

  ftoi_ctrl #(
    .INT_W(INT_W), .NARROW_W(NARROW_W), .MANT_W(MANT_W),
    .EXP_W(EXP_W), .SH_W(SH_W)
  ) u_ctrl (
    .inValid(inValid),
    .inWide (inWide),
    .inSign (inSign),
    .inClass(inClass),
    .inExp  (inExp),
    .ctrl   (ctrl),
    .shAmt  (shAmt)
  );

  ftoi_dpath #(
    .INT_W(INT_W), .NARROW_W(NARROW_W), .MANT_W(MANT_W), .SH_W(SH_W)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .shAmt     (shAmt),
    .inMant    (inMant),
    .inSticky  (inSticky),
    .outValid  (outValid),
    .outData   (outData),
    .outInvalid(outInvalid),
    .outInexact(outInexact)
  );

endmodule

// File: rtl/ftoi_trunc_chk.sv
module ftoi_trunc_chk #(
  parameter int INT_W    = 64,
  parameter int NARROW_W = 32,
  parameter int EXP_W    = 12
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    inValid,
  input logic                    inWide,
  input logic                    inSign,
  input logic [1:0]              inClass,
  input logic signed [EXP_W-1:0] inExp,
  input logic                    outValid,
  input logic [INT_W-1:0]        outData,
  input logic                    outInvalid,
  input logic                    outInexact
);

  localparam logic [INT_W-1:0] WIDE_MAX   = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic [INT_W-1:0] NARROW_MAX = INT_W'({1'b0, {(NARROW_W-1){1'b1}}});

  logic expTooBig;
  assign expTooBig = inWide ? (inExp >= EXP_W'(INT_W)) : (inExp >= EXP_W'(NARROW_W));

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    outValid == $past(inValid && rstN)); // R2

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    $past(!inValid) |-> ($stable(outData) && $stable(outInvalid) && $stable(outInexact))); // R2

  AST_ZERO_CLASS: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(inClass) == 2'd0) |-> (outData == '0 && !outInvalid && !outInexact)); // R3

  AST_RESULT_SIGN: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outInvalid && outData != '0) |->
      (($past(inWide) ? outData[INT_W-1] : outData[NARROW_W-1]) == $past(inSign))); // R5

  AST_EXP_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(inClass == 2'd1 && expTooBig)) |-> outInvalid); // R8

  AST_SPECIAL_INVALID: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(inClass[1])) |-> outInvalid); // R10

  AST_SAT_VALUE: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outInvalid) |->
      (outData == (($past(inWide) ? WIDE_MAX : NARROW_MAX) + INT_W'($past(inSign))))); // R11

  AST_FLAG_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !(outInvalid && outInexact)); // R11

  AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !$past(inWide)) |-> (outData[INT_W-1:NARROW_W] == '0)); // R12

endmodule

bind ftoi_trunc ftoi_trunc_chk #(
  .INT_W(INT_W), .NARROW_W(NARROW_W), .EXP_W(EXP_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .inValid   (inValid),
  .inWide    (inWide),
  .inSign    (inSign),
  .inClass   (inClass),
  .inExp     (inExp),
  .outValid  (outValid),
  .outData   (outData),
  .outInvalid(outInvalid),
  .outInexact(outInexact)
);

// File: tb/ftoi_trunc_bench.sv
module ftoi_trunc_bench;

  localparam logic [65:0] ONE = 66'h2_0000_0000_0000_0000;

  typedef struct packed {
    logic               wide;
    logic               sign;
    logic [1:0]         cls;
    logic signed [11:0] exp;
    logic [65:0]        mant;
    logic               stk;
    logic [63:0]        data;
    logic               inv;
    logic               inx;
  } vec_t;

  localparam int NVEC = 23;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b0, 2'd1, 12'sd0,  ONE, 1'b0, 64'h1, 1'b0, 1'b0},                              // R4 one
    '{1'b0, 1'b1, 2'd1, 12'sd0,  ONE, 1'b0, 64'h0000_0000_FFFF_FFFF, 1'b0, 1'b0},            // R5 minus one
    '{1'b0, 1'b0, 2'd1, 12'sd1,  66'h3_0000_0000_0000_0000, 1'b0, 64'h3, 1'b0, 1'b0},        // R4 three
    '{1'b0, 1'b0, 2'd1, 12'sd0,  66'h3_0000_0000_0000_0000, 1'b0, 64'h1, 1'b0, 1'b1},        // R6 1.5
    '{1'b0, 1'b1, 2'd1, 12'sd0,  66'h3_0000_0000_0000_0000, 1'b0, 64'h0000_0000_FFFF_FFFF, 1'b0, 1'b1}, // R5 -1.5
    '{1'b0, 1'b0, 2'd1, -12'sd1, ONE, 1'b0, 64'h0, 1'b0, 1'b1},                              // R7 0.5
    '{1'b0, 1'b0, 2'd1, 12'sd31, ONE, 1'b0, 64'h7FFF_FFFF, 1'b1, 1'b0},                      // R9 +2^31
    '{1'b0, 1'b1, 2'd1, 12'sd31, ONE, 1'b0, 64'h8000_0000, 1'b0, 1'b0},                      // R9 -2^31
    '{1'b0, 1'b1, 2'd1, 12'sd31, 66'h2_0000_0004_0000_0000, 1'b0, 64'h8000_0000, 1'b1, 1'b0},// R9 -(2^31+1)
    '{1'b0, 1'b1, 2'd1, 12'sd31, 66'h2_0000_0002_0000_0000, 1'b0, 64'h8000_0000, 1'b0, 1'b1},// R9 -(2^31+0.5)
    '{1'b0, 1'b0, 2'd1, 12'sd32, ONE, 1'b0, 64'h7FFF_FFFF, 1'b1, 1'b0},                      // R8 narrow
    '{1'b0, 1'b0, 2'd1, 12'sd30, 66'h3_FFFF_FFFF_FFFF_FFFF, 1'b0, 64'h7FFF_FFFF, 1'b0, 1'b1},// R6 max narrow
    '{1'b1, 1'b0, 2'd1, 12'sd63, ONE, 1'b0, 64'h7FFF_FFFF_FFFF_FFFF, 1'b1, 1'b0},            // R9 +2^63
    '{1'b1, 1'b1, 2'd1, 12'sd63, ONE, 1'b0, 64'h8000_0000_0000_0000, 1'b0, 1'b0},            // R9 -2^63
    '{1'b1, 1'b0, 2'd1, 12'sd40, ONE, 1'b0, 64'h0000_0100_0000_0000, 1'b0, 1'b0},            // R4 2^40
    '{1'b1, 1'b1, 2'd1, 12'sd32, ONE, 1'b0, 64'hFFFF_FFFF_0000_0000, 1'b0, 1'b0},            // R5 -2^32
    '{1'b1, 1'b0, 2'd1, 12'sd64, ONE, 1'b0, 64'h7FFF_FFFF_FFFF_FFFF, 1'b1, 1'b0},            // R8 wide
    '{1'b0, 1'b1, 2'd2, 12'sd0,  ONE, 1'b0, 64'h8000_0000, 1'b1, 1'b0},                      // R10 -inf
    '{1'b1, 1'b0, 2'd3, 12'sd0,  ONE, 1'b1, 64'h7FFF_FFFF_FFFF_FFFF, 1'b1, 1'b0},            // R10 nan
    '{1'b1, 1'b1, 2'd0, 12'sd50, ONE, 1'b1, 64'h0, 1'b0, 1'b0},                              // R3 zero
    '{1'b0, 1'b0, 2'd1, 12'sd0,  ONE, 1'b1, 64'h1, 1'b0, 1'b1},                              // R6 sticky
    '{1'b1, 1'b0, 2'd1, 12'sd62, 66'h3_FFFF_FFFF_FFFF_FFF8, 1'b0, 64'h7FFF_FFFF_FFFF_FFFF, 1'b0, 1'b0}, // R11 max wide exact
    '{1'b0, 1'b1, 2'd1, -12'sd5, 66'h0, 1'b0, 64'h0, 1'b0, 1'b0}                             // R7 exact zero
  };

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               inValid = 1'b0;
  logic               inWide = 1'b0;
  logic               inSign = 1'b0;
  logic [1:0]         inClass = 2'd0;
  logic signed [11:0] inExp = '0;
  logic [65:0]        inMant = '0;
  logic               inSticky = 1'b0;
  logic               outValid;
  logic [63:0]        outData;
  logic               outInvalid;
  logic               outInexact;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 1'b0;

  always #5 clk = ~clk;

  ftoi_trunc u_ftoi_trunc (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inWide(inWide), .inSign(inSign),
    .inClass(inClass), .inExp(inExp), .inMant(inMant), .inSticky(inSticky),
    .outValid(outValid), .outData(outData), .outInvalid(outInvalid), .outInexact(outInexact)
  );

  task automatic checkOut(input string tag, input logic expV, input logic [63:0] expD,
                          input logic expInv, input logic expInx);
    nChecks++;
    if (outValid !== expV || outData !== expD || outInvalid !== expInv || outInexact !== expInx) begin
      nFails++;
      $display("FAIL %s: got valid=%0b data=%h inv=%0b inx=%0b, expected valid=%0b data=%h inv=%0b inx=%0b",
               tag, outValid, outData, outInvalid, outInexact, expV, expD, expInv, expInx);
    end
  endtask

  task automatic apply(input logic w, input logic s, input logic [1:0] c,
                       input logic signed [11:0] e, input logic [65:0] m, input logic st);
    @(negedge clk);
    inWide = w; inSign = s; inClass = c; inExp = e; inMant = m; inSticky = st;
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  // independent arithmetic model of the requirements
  task automatic model(input logic w, input logic s, input logic [1:0] c,
                       input logic signed [11:0] e, input logic [65:0] m, input logic st,
                       output logic [63:0] d, output logic inv, output logic inx);
    logic [65:0] mg;
    logic        lostBits;
    logic [66:0] bound;
    int          lim;
    lim = w ? 64 : 32;
    d = '0; inv = 1'b0; inx = 1'b0;
    if (c == 2'd0) return;
    if (c[1] || int'(e) >= lim) begin
      inv = 1'b1;
      d = w ? (64'h7FFF_FFFF_FFFF_FFFF + 64'(s)) : (64'h7FFF_FFFF + 64'(s));
      return;
    end
    if (e < 0) begin
      mg = '0;
      lostBits = (m != '0) || st;
    end else begin
      mg = m >> (65 - int'(e));
      lostBits = ((mg << (65 - int'(e))) != m) || st;
    end
    bound = (67'(1) << (lim - 1)) + 67'(s);
    if ({1'b0, mg} >= bound) begin
      inv = 1'b1;
      d = w ? (64'h7FFF_FFFF_FFFF_FFFF + 64'(s)) : (64'h7FFF_FFFF + 64'(s));
      return;
    end
    d = s ? (64'd0 - mg[63:0]) : mg[63:0];
    if (!w) d = {32'd0, d[31:0]};
    inx = lostBits;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: got no completion, expected completion within 200000 cycles");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    logic        inv, inx;
    logic [63:0] heldData;
    logic        heldInv, heldInx;

    // R1: reset state, even with a request pending
    inValid = 1'b1; inClass = 2'd1; inMant = ONE; inExp = 12'sd3;
    repeat (3) @(negedge clk);
    checkOut("R1 during reset", 1'b0, 64'h0, 1'b0, 1'b0);
    inValid = 1'b0;
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    checkOut("R1 after reset", 1'b0, 64'h0, 1'b0, 1'b0);

    // table of boundary vectors
    for (int i = 0; i < NVEC; i++) begin
      apply(VECS[i].wide, VECS[i].sign, VECS[i].cls, VECS[i].exp, VECS[i].mant, VECS[i].stk);
      checkOut($sformatf("vector %0d (R3-R12 table)", i), 1'b1, VECS[i].data, VECS[i].inv, VECS[i].inx);
    end

    // R2: one-cycle latency and hold while idle with changing inputs
    apply(1'b0, 1'b1, 2'd1, 12'sd4, 66'h2_8000_0000_0000_0000, 1'b0); // -(2^4 * 1.25) = -20
    checkOut("R2 latency", 1'b1, 64'h0000_0000_FFFF_FFEC, 1'b0, 1'b0);
    heldData = outData; heldInv = outInvalid; heldInx = outInexact;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      inClass = 2'd3; inExp = 12'sd90; inSign = 1'b0; inSticky = 1'b1;
    end
    checkOut("R2 hold while idle", 1'b0, heldData, heldInv, heldInx);

    // R3: zero class with every other input set
    apply(1'b0, 1'b1, 2'd0, 12'sd100, 66'h3_FFFF_FFFF_FFFF_FFFF, 1'b1);
    checkOut("R3 zero class ignores operands", 1'b1, 64'h0, 1'b0, 1'b0);

    // R7: deeply negative exponent, only sticky set
    apply(1'b1, 1'b1, 2'd1, -12'sd200, 66'h0, 1'b1);
    checkOut("R7 negative exponent sticky", 1'b1, 64'h0, 1'b0, 1'b1);

    // back-to-back requests
    @(negedge clk);
    inWide = 1'b1; inSign = 1'b0; inClass = 2'd1; inExp = 12'sd10; inMant = ONE; inSticky = 1'b0;
    inValid = 1'b1;
    @(negedge clk);
    checkOut("R2 back-to-back first", 1'b1, 64'd1024, 1'b0, 1'b0);
    inExp = 12'sd11;
    @(negedge clk);
    inValid = 1'b0;
    checkOut("R2 back-to-back second", 1'b1, 64'd2048, 1'b0, 1'b0);

    // random comparison against the model (R4, R5, R6, R8, R9)
    for (int n = 0; n < 400; n++) begin
      logic               w, s, st;
      logic [1:0]         c;
      logic signed [11:0] e;
      logic [65:0]        m;
      w  = 1'($urandom);
      s  = 1'($urandom);
      st = ($urandom_range(0, 3) == 0);
      c  = ($urandom_range(0, 9) == 0) ? 2'($urandom) : 2'd1;
      e  = 12'($signed($urandom_range(0, 74)) - 5);
      m  = {2'b10 | 2'($urandom), $urandom, $urandom};
      if ($urandom_range(0, 3) == 0) m[31:0] = '0;
      model(w, s, c, e, m, st, d, inv, inx);
      apply(w, s, c, e, m, st);
      checkOut($sformatf("R4 random %0d", n), 1'b1, d, inv, inx);
    end

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule